// File: doc/BRIEF.md
# Multi-Link Packet Framer and Round-Robin Merger

This block collects packets from several independent 16-bit streaming links, frames each packet with a small header, and merges all links into one wide output stream. Each link sends a flags word, then four timestamp words, then a payload of any length. Every link has its own input FIFO. A packet leaves the block only after it has been buffered in full, so the header can carry the packet length.

The merger visits the links in a fixed order and takes exactly one whole packet from each link. One complete pass over the links is called a write-run. Because of this, the packets that share a time period stay next to each other in the output. If the link whose turn it is has no complete packet yet, the merger waits for that link and does not skip it. The 16-bit words are packed four to a 64-bit beat. The last beat of a run is padded with zeros and marked. A one-cycle pulse then reports the run's first timestamp and its word count, for use by a later indexing stage.

Top module: `spf_merger`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `run_done` are 0.
- R2: While `fifo_en` is 0, every `in_ready` bit is 0 and no input word is taken. A word offered during that time never appears in the output.
- R3: Each packet is emitted as 0xBEEF, a length word, a link-number word and 0xCAFE, followed by the packet's own words in arrival order.
- R4: The length word equals the number of 16-bit words in the packet that follows the header. The packet is framed by `in_sop` on its first word and `in_eop` on its last word.
- R5: Links are served in the order 0, 1, …, N-1, one complete packet each, and then the order repeats. While the link whose turn it is has no complete packet, nothing is emitted, even if other links hold complete packets.
- R6: Output word k of a beat is carried on `out_data[16k+15:16k]`. The first word of the stream goes in the lowest lane.
- R7: The last beat of each run has `out_last` = 1, and its unused lanes are 0. `out_last` is 0 on every other beat. When a run fills its last beat exactly, no padding beat is added.
- R8: `run_done` pulses for one cycle in the same cycle that the last beat of the run first shows valid. At that point `run_ts` holds link 0's four timestamp words for the run, first word most significant. `run_words` holds the number of 16-bit words in the run, counting headers and excluding padding.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values in the next cycle.
- R10: A link's `in_ready` falls to 0 once its FIFO holds DEPTH words. It rises again when the merger drains that FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Enables input acceptance on all links |
| in_valid | input | N_LINKS | Per-link word valid |
| in_sop | input | N_LINKS | Per-link first word of packet |
| in_eop | input | N_LINKS | Per-link last word of packet |
| in_data | input | 16*N_LINKS | Per-link word, link i in bits [16i+15:16i] |
| in_ready | output | N_LINKS | Per-link word accepted when valid and ready |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 16*LANES | Packed output beat |
| out_last | output | 1 | Last beat of a write-run |
| out_ready | input | 1 | Downstream accepts the beat |
| run_done | output | 1 | One-cycle pulse at the end of a write-run |
| run_ts | output | 64 | First timestamp of the finished run |
| run_words | output | 32 | 16-bit word count of the finished run |

## Verification
Two functions can fall in the same cycle. In the first, a link FIFO takes a new word, and possibly a packet's end, while the merger pops a word or a packet length from that same FIFO. In the second, the final word of a run closes a padded beat while the output is stalled. Both are provoked on purpose. One link is loaded with two packets until its FIFO is full, while link 0 holds back, and the run is then released with `out_ready` toggling. The scoreboard judges the result from the complete expected beat stream and from the per-run timestamp and word count. Any lost, duplicated or reordered word, and any wrongly placed last flag, shows up as a mismatch.

// File: rtl/spf_pkg.sv
// Package: shared constants and state type for the packet framer/merger.
package spf_pkg;
    localparam logic [15:0] HDR_OPEN  = 16'hBEEF;
    localparam logic [15:0] HDR_CLOSE = 16'hCAFE;
    localparam int          HDR_WORDS = 4;
    localparam int          TS_WORDS  = 4;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } merge_state_t;
endpackage

// File: rtl/spf_link_fifo.sv
// Module: spf_link_fifo
// Buffers the words of one link and keeps a small queue of complete-packet
// lengths. A packet becomes visible to the reader only once its last word
// is stored. Assumes that no packet is longer than DEPTH words.
module spf_link_fifo #(
    parameter int DEPTH = 64,
    parameter int SLOTS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [15:0] in_data,
    output logic        in_ready,
    output logic [15:0] head,
    output logic        pkt_avail,
    output logic [15:0] pkt_len,
    input  logic        pop_word,
    input  logic        pop_pkt
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int SCW = $clog2(SLOTS + 1);

    logic [15:0]  mem  [DEPTH];
    logic [15:0]  lmem [SLOTS];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [SW-1:0] lwp, lrp;
    logic [SCW-1:0] lcnt;
    logic [15:0]  acc_len;
    logic [15:0]  len_now;
    logic         push, lpush;

    assign in_ready  = en && (cnt != CW'(DEPTH)) && (lcnt != SCW'(SLOTS));
    assign push      = in_valid && in_ready;
    assign lpush     = push && in_eop;
    assign len_now   = in_sop ? 16'd1 : acc_len + 16'd1;
    assign head      = mem[rp];
    assign pkt_avail = (lcnt != '0);
    assign pkt_len   = lmem[lrp];

    // Store accepted words and finished packet lengths.
    always_ff @(posedge clk) begin
        if (push)  mem[wp]   <= in_data;
        if (lpush) lmem[lwp] <= len_now;
    end

    // Advance pointers, occupancy counts and the running packet length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; cnt <= '0;
            lwp <= '0; lrp <= '0; lcnt <= '0;
            acc_len <= '0;
        end else begin
            if (push) begin
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
                acc_len <= in_eop ? 16'd0 : len_now;
            end
            if (pop_word) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop_word})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (lpush)   lwp <= (lwp == SW'(SLOTS - 1)) ? '0 : lwp + 1'b1;
            if (pop_pkt) lrp <= (lrp == SW'(SLOTS - 1)) ? '0 : lrp + 1'b1;
            case ({lpush, pop_pkt})
                2'b10:   lcnt <= lcnt + 1'b1;
                2'b01:   lcnt <= lcnt - 1'b1;
                default: lcnt <= lcnt;
            endcase
        end
    end

    // R5
    word_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_word |-> (cnt != '0));
    // R5
    len_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_pkt |-> (lcnt != '0));
endmodule

// File: rtl/spf_packer.sv
// Module: spf_packer
// Gathers 16-bit words into beats of LANES words, with the first word in the
// lowest lane. A flush word closes the beat early, zero-fills the rest of
// the beat and marks it last. Holds a beat steady while the output stalls.
module spf_packer #(
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                w_valid,
    input  logic [15:0]         w_data,
    input  logic                w_flush,
    output logic                w_ready,
    output logic                out_valid,
    output logic [16*LANES-1:0] out_data,
    output logic                out_last,
    input  logic                out_ready
);
    localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [16*LANES-1:0] acc;
    logic [16*LANES-1:0] beat;
    logic [CW-1:0]       cnt;

    assign w_ready = !out_valid || out_ready;

    // Place the incoming word into the lane given by the fill count.
    always_comb begin
        beat = acc;
        beat[cnt*16 +: 16] = w_data;
    end

    // Fill lanes, then present a beat and hold it until it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0; cnt <= '0;
            out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (w_valid && w_ready) begin
                if (cnt == CW'(LANES - 1) || w_flush) begin
                    out_data  <= beat;
                    out_valid <= 1'b1;
                    out_last  <= w_flush;
                    acc       <= '0;
                    cnt       <= '0;
                end else begin
                    acc <= beat;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/spf_merger.sv
// Module: spf_merger (top)
// One FIFO per link. The links are served in strict rotation, one complete
// packet each, and each packet gets a four-word header (open magic, length,
// link number, close magic). The word stream is packed into wide beats. The
// last word of link N-1 closes the write-run: it pads the beat, marks it last
// and reports the run's first timestamp and word count. Single clock domain.
module spf_merger
    import spf_pkg::*;
#(
    parameter int N_LINKS = 8,
    parameter int DEPTH   = 64,
    parameter int SLOTS   = 4,
    parameter int LANES   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fifo_en,
    input  logic [N_LINKS-1:0]     in_valid,
    input  logic [N_LINKS-1:0]     in_sop,
    input  logic [N_LINKS-1:0]     in_eop,
    input  logic [16*N_LINKS-1:0]  in_data,
    output logic [N_LINKS-1:0]     in_ready,
    output logic                   out_valid,
    output logic [16*LANES-1:0]    out_data,
    output logic                   out_last,
    input  logic                   out_ready,
    output logic                   run_done,
    output logic [63:0]            run_ts,
    output logic [31:0]            run_words
);
    localparam int LW = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;

    logic [15:0]        head  [N_LINKS];
    logic [15:0]        plen  [N_LINKS];
    logic [N_LINKS-1:0] avail;
    logic [N_LINKS-1:0] pop_word, pop_pkt;

    merge_state_t state;
    logic [LW-1:0] cur;
    logic [15:0]   idx, cur_len;
    logic [63:0]   ts_acc;
    logic [31:0]   words_cnt;
    logic          w_valid, w_ready, w_flush, take;
    logic [15:0]   w_data;

    // One buffered input per link.
    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        spf_link_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_fifo (
            .clk(clk), .rst_n(rst_n), .en(fifo_en),
            .in_valid(in_valid[g]), .in_sop(in_sop[g]), .in_eop(in_eop[g]),
            .in_data(in_data[g*16 +: 16]), .in_ready(in_ready[g]),
            .head(head[g]), .pkt_avail(avail[g]), .pkt_len(plen[g]),
            .pop_word(pop_word[g]), .pop_pkt(pop_pkt[g])
        );
    end

    // Select the word to emit: a header word or the current link's FIFO head.
    always_comb begin
        w_valid = (state != ST_WAIT);
        w_data  = head[cur];
        if (state == ST_HDR) begin
            case (idx[1:0])
                2'd0:    w_data = HDR_OPEN;
                2'd1:    w_data = cur_len;
                2'd2:    w_data = 16'(cur);
                default: w_data = HDR_CLOSE;
            endcase
        end
        w_flush = (state == ST_BODY) && (cur == LW'(N_LINKS - 1)) && (idx == cur_len - 16'd1);
    end

    assign take = w_valid && w_ready;

    // Pop strobes for the link being served.
    always_comb begin
        pop_word = '0;
        pop_pkt  = '0;
        if (state == ST_BODY && take)     pop_word[cur] = 1'b1;
        if (state == ST_WAIT && avail[cur]) pop_pkt[cur] = 1'b1;
    end

    // Rotation state machine and write-run bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT; cur <= '0; idx <= '0; cur_len <= '0;
            ts_acc <= '0; words_cnt <= '0;
            run_done <= 1'b0; run_ts <= '0; run_words <= '0;
        end else begin
            run_done <= take && w_flush;
            if (take) words_cnt <= words_cnt + 32'd1;
            if (take && w_flush) begin
                run_words <= words_cnt + 32'd1;
                run_ts    <= ts_acc;
                words_cnt <= '0;
            end
            case (state)
                ST_WAIT: if (avail[cur]) begin
                    cur_len <= plen[cur];
                    idx     <= '0;
                    state   <= ST_HDR;
                end
                ST_HDR: if (take) begin
                    idx <= (idx == 16'(HDR_WORDS - 1)) ? 16'd0 : idx + 16'd1;
                    if (idx == 16'(HDR_WORDS - 1)) state <= ST_BODY;
                end
                default: if (take) begin
                    if (cur == '0 && idx >= 16'd1 && idx <= 16'(TS_WORDS))
                        ts_acc <= {ts_acc[47:0], head[cur]};
                    idx <= idx + 16'd1;
                    if (idx == cur_len - 16'd1) begin
                        state <= ST_WAIT;
                        cur   <= (cur == LW'(N_LINKS - 1)) ? '0 : cur + 1'b1;
                    end
                end
            endcase
        end
    end

    spf_packer #(.LANES(LANES)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .w_valid(w_valid), .w_data(w_data), .w_flush(w_flush), .w_ready(w_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    // R8
    run_end_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> (out_valid && out_last));
    // R8
    run_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done);
endmodule

// File: tb/spf_merger_tb_top.sv
// Scoreboard bench: the run-planning task pushes the expected beats and run
// reports; the monitor pops and compares them as the design produces them.
module spf_merger_tb_top;
    localparam int N  = 4;
    localparam int DP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0;
    logic [N-1:0]  in_valid = '0, in_sop = '0, in_eop = '0;
    logic [16*N-1:0] in_data = '0;
    logic [N-1:0]  in_ready;
    logic          out_valid, out_last, run_done;
    logic          out_ready = 1'b1;
    logic [63:0]   out_data, run_ts;
    logic [31:0]   run_words;

    int total = 0, bad = 0;
    bit done = 0, bp_mode = 0;
    logic [64:0] exp_beats[$];
    logic [95:0] exp_runs[$];
    int          r_len [N];
    logic [63:0] r_ts  [N];
    logic [15:0] r_seed[N];

    always #5 clk = ~clk;

    spf_merger #(.N_LINKS(N), .DEPTH(DP), .SLOTS(4), .LANES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready), .run_done(run_done),
        .run_ts(run_ts), .run_words(run_words)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] pkt_word(int k, logic [63:0] ts, logic [15:0] seed);
        if (k == 0) return seed;
        if (k <= 4) return 16'(ts >> (16 * (4 - k)));
        return seed + 16'(k);
    endfunction

    // Build the expected stream of one write-run from r_len/r_ts/r_seed.
    task automatic expect_run();
        logic [15:0] w[$];
        logic [63:0] beat;
        for (int l = 0; l < N; l++) begin
            w.push_back(16'hBEEF); w.push_back(16'(r_len[l]));
            w.push_back(16'(l));   w.push_back(16'hCAFE);
            for (int k = 0; k < r_len[l]; k++) w.push_back(pkt_word(k, r_ts[l], r_seed[l]));
        end
        for (int i = 0; i < w.size(); i += 4) begin
            beat = '0;
            for (int j = 0; j < 4; j++)
                if (i + j < w.size()) beat[16*j +: 16] = w[i+j];
            exp_beats.push_back({(i + 4 >= w.size()), beat});
        end
        exp_runs.push_back({32'(w.size()), r_ts[0]});
    endtask

    task automatic send_pkt(input int l, input int len, input logic [63:0] ts, input logic [15:0] seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid[l] = 1'b1; in_sop[l] = (k == 0); in_eop[l] = (k == len - 1);
            in_data[l*16 +: 16] = pkt_word(k, ts, seed);
            #1;
            while (!in_ready[l]) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid[l] = 1'b0; in_sop[l] = 1'b0; in_eop[l] = 1'b0;
    endtask

    task automatic set_run(input int l, input int len, input logic [63:0] ts, input logic [15:0] seed);
        r_len[l] = len; r_ts[l] = ts; r_seed[l] = seed;
    endtask

    task automatic drain();
        while (exp_beats.size() != 0 || exp_runs.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Output ready pattern: toggles under backpressure mode.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // Monitor: compares beats and run reports; checks stall hold.
    initial begin
        logic [64:0] e;
        logic [95:0] er;
        logic        prev_stall = 0;
        logic [64:0] prev_beat = '0;
        forever begin
            @(negedge clk); #2;
            if (rst_n) begin
                if (prev_stall)
                    chk(out_valid && {out_last, out_data} == prev_beat, "R9 hold under stall",
                        96'({out_valid, out_last, out_data}), 96'({1'b1, prev_beat}));
                if (out_valid && out_ready) begin
                    if (exp_beats.size() == 0) chk(0, "R3 unexpected beat", 96'(out_data), 96'(0));
                    else begin
                        e = exp_beats.pop_front();
                        chk(out_data == e[63:0], "R3 R4 R5 R6 beat data", 96'(out_data), 96'(e[63:0]));
                        chk(out_last == e[64], "R7 last flag", 96'(out_last), 96'(e[64]));
                    end
                end
                if (run_done) begin
                    chk(out_valid && out_last, "R8 run_done on last beat", 96'({out_valid, out_last}), 96'(3));
                    if (exp_runs.size() == 0) chk(0, "R8 unexpected run_done", 96'(run_words), 96'(0));
                    else begin
                        er = exp_runs.pop_front();
                        chk(run_ts == er[63:0], "R8 run_ts", 96'(run_ts), 96'(er[63:0]));
                        chk(run_words == er[95:64], "R8 run_words", 96'(run_words), 96'(er[95:64]));
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_beat  = {out_last, out_data};
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        #2;
        chk(!out_valid && !run_done, "R1 reset outputs", 96'({out_valid, run_done}), 96'(0));
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk); #2;
        chk(!out_valid && !run_done, "R1 after reset", 96'({out_valid, run_done}), 96'(0));

        // R2: disabled FIFOs take nothing
        @(negedge clk);
        in_valid = '1; in_sop = '1; in_eop = '1; in_data = {4{16'h5A5A}};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            if (i % 3 == 0) chk(in_ready == '0, "R2 in_ready while disabled", 96'(in_ready), 96'(0));
        end
        chk(!out_valid, "R2 no output from disabled input", 96'(out_valid), 96'(0));
        @(negedge clk);
        in_valid = '0; in_sop = '0; in_eop = '0;
        @(negedge clk); fifo_en = 1'b1;

        // Run A: mixed lengths, padded last beat
        set_run(0, 6, 64'h1111_2222_3333_4444, 16'h0100);
        set_run(1, 7, 64'hA1A1_B2B2_C3C3_D4D4, 16'h0200);
        set_run(2, 5, 64'h0000_0000_0000_0007, 16'h0300);
        set_run(3, 9, 64'hFFFF_0000_FFFF_0001, 16'h0400);
        expect_run();
        fork
            send_pkt(0, 6, 64'h1111_2222_3333_4444, 16'h0100);
            send_pkt(1, 7, 64'hA1A1_B2B2_C3C3_D4D4, 16'h0200);
            send_pkt(2, 5, 64'h0000_0000_0000_0007, 16'h0300);
            send_pkt(3, 9, 64'hFFFF_0000_FFFF_0001, 16'h0400);
        join
        drain();

        // Runs B and C: link 0 late, link 1 overfilled, backpressure on
        set_run(0, 8,  64'h0B00_0B01_0B02_0B03, 16'h1100);
        set_run(1, 14, 64'h0B10_0B11_0B12_0B13, 16'h1200);
        set_run(2, 6,  64'h0B20_0B21_0B22_0B23, 16'h1300);
        set_run(3, 5,  64'h0B30_0B31_0B32_0B33, 16'h1400);
        expect_run();
        set_run(0, 5,  64'h0C00_0C01_0C02_0C03, 16'h2100);
        set_run(1, 10, 64'h0C10_0C11_0C12_0C13, 16'h2200);
        set_run(2, 7,  64'h0C20_0C21_0C22_0C23, 16'h2300);
        set_run(3, 6,  64'h0C30_0C31_0C32_0C33, 16'h2400);
        expect_run();
        bp_mode = 1;
        fork
            begin
                send_pkt(1, 14, 64'h0B10_0B11_0B12_0B13, 16'h1200);
                send_pkt(1, 10, 64'h0C10_0C11_0C12_0C13, 16'h2200);
            end
            begin
                send_pkt(2, 6, 64'h0B20_0B21_0B22_0B23, 16'h1300);
                send_pkt(3, 5, 64'h0B30_0B31_0B32_0B33, 16'h1400);
            end
            begin
                repeat (60) @(negedge clk);
                #2;
                chk(!out_valid, "R5 waits for link 0", 96'(out_valid), 96'(0));
                chk(in_ready[1] == 1'b0, "R10 full FIFO not ready", 96'(in_ready[1]), 96'(0));
                send_pkt(0, 8, 64'h0B00_0B01_0B02_0B03, 16'h1100);
                send_pkt(0, 5, 64'h0C00_0C01_0C02_0C03, 16'h2100);
                send_pkt(2, 7, 64'h0C20_0C21_0C22_0C23, 16'h2300);
                send_pkt(3, 6, 64'h0C30_0C31_0C32_0C33, 16'h2400);
            end
        join
        drain();
        chk(in_ready[1] == 1'b1, "R10 ready after drain", 96'(in_ready[1]), 96'(1));
        bp_mode = 0;

        // Run D: exact fill, no padding beat
        for (int l = 0; l < N; l++) set_run(l, 5, 64'(64'hD000 + l), 16'(16'h3000 + 16'h100 * l));
        expect_run();
        fork
            send_pkt(3, 5, 64'hD003, 16'h3300);
            send_pkt(2, 5, 64'hD002, 16'h3200);
            send_pkt(1, 5, 64'hD001, 16'h3100);
            send_pkt(0, 5, 64'hD000, 16'h3000);
        join
        drain();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule